// File: doc/BRIEF.md
# Fractional-Divisor Serial Receiver

This block receives asynchronous serial characters using a bit period that need not be a whole number of clocks. A configuration word gives an integer clock count per bit, a fraction in 1/256 steps and a data-bit count. Each time the bit timer reaches a sample point, the fraction is added into an 8-bit accumulator. When that addition carries out, the next bit interval is one clock longer. Over many bits, the average interval therefore equals the integer plus the fraction.

The accumulator keeps its value across characters and across periods when the receiver is disabled. Only the chip reset clears it, so the fractional rate is carried through the whole stream instead of restarting at every frame.

The serial line passes through a synchronizer. A frame starts on a falling edge seen while the receiver is enabled. The start bit is checked again half a period later. Data is then shifted in least-significant bit first at the top of a 32-bit register, and the stop bit is checked. The completed register is presented with a one-cycle strobe and a framing flag. Holding the enable low stops reception and loads a new configuration word, which takes effect when the enable rises again.

Top module: `frac_uart_rx`

## Requirements
- R1: While `rx_en` is low no frame is in progress and `rx_valid` stays 0. Dropping `rx_en` in the middle of a frame abandons it with no strobe. After reset `rx_valid` and `rx_frame_err` are 0.
- R2: A frame begins only on a high-to-low transition of the synchronized line seen while enabled. If the line is already low when `rx_en` rises, no frame begins until the line has been high.
- R3: The start bit is sampled `floor(int/2)` clocks after the falling edge is detected. If it reads high, the frame is dropped without a strobe.
- R4: The data-bit count N is `cfg[4:0]+1`. Bits arrive least-significant first and shift in at bit 31, so the character ends up in `rx_word[31:32-N]`. All lower bits of `rx_word` are 0.
- R5: The integer clocks per bit are `cfg[31:16]` and the fraction is `cfg[15:8]` in 1/256 units. At every sample point the fraction is added to an 8-bit accumulator. The next interval is the integer plus the carry out of that addition.
- R6: The fraction accumulator is cleared only by `rst_n`. It is not cleared between characters or by `rx_en` low, and it does not change while the receiver is disabled.
- R7: After the stop-bit sample, `rx_valid` pulses for exactly one cycle. `rx_frame_err` is 1 in that same cycle if the stop bit read low, and is never 1 without `rx_valid`.
- R8: `baud_cfg` is captured on every clock while `rx_en` is low. Changes to it while enabled have no effect.
- R9: With the integer set to 10 and no fraction (2 Mbaud from 20 MHz), back-to-back 8-bit characters with two stop bits are received correctly. So are characters with one stop bit at a fractional divisor.
- R10: `rx_word` changes only in a cycle where `rx_valid` is 1, and holds its value between strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd | input | 1 | Serial line, idle high |
| rx_en | input | 1 | Receiver enable; low holds the receiver idle and loads `baud_cfg` |
| baud_cfg | input | 32 | Integer [31:16], fraction [15:8], data bits minus one [4:0] |
| rx_word | output | 32 | Last received character, aligned at the top |
| rx_valid | output | 1 | One-cycle strobe for a completed frame |
| rx_frame_err | output | 1 | Stop bit read low; valid only with `rx_valid` |

## Verification
The bound checker watches properties that must hold on every cycle:
- the strobe is a single-cycle pulse;
- the framing flag never appears without the strobe;
- the receiver stays quiet while disabled;
- the output word holds between strobes;
- the captured configuration stays frozen while enabled;
- the accumulator stays frozen while disabled.

The fractional timing can only be shown by the bench's scenarios. These include long back-to-back streams at an 10.875-clock divisor, where ignoring the carry would land the later samples in the wrong bit, and a reference model compared on every clock. The bench scenarios also cover start rejection on a glitch, enabling with the line held low, a mid-frame disable, short word sizes and configuration updates.

// File: rtl/frac_uart_pkg.sv
package frac_uart_pkg;

  localparam int DIV_W  = 16;
  localparam int FRAC_W = 8;
  localparam int NB_W   = 5;
  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;

  typedef struct packed {
    logic [DIV_W-1:0]  div_int;
    logic [FRAC_W-1:0] div_frac;
    logic [NB_W-1:0]   nbits_m1;
  } rx_cfg_t;

endpackage

// File: rtl/frac_rx_sync.sv
module frac_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic rxd,
  output logic line,
  output logic fall
);

  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= rxd;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], rxd};
      end
    end
  endgenerate

  assign line = chain_q[STAGES-1];

  // previous line level is forgotten while disabled, so a line that is
  // already low at enable cannot look like a falling edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= en & line;
  end

  assign fall = en & prev_q & ~line;

endmodule

// File: rtl/frac_bit_timer.sv
module frac_bit_timer #(
  parameter int DIV_W  = frac_uart_pkg::DIV_W,
  parameter int FRAC_W = frac_uart_pkg::FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              run,
  input  logic [DIV_W-1:0]  div_int,
  input  logic [FRAC_W-1:0] div_frac,
  output logic              tick,
  output logic [FRAC_W-1:0] acc
);

  logic [DIV_W-1:0]  cnt_q, cnt_d;
  logic [FRAC_W-1:0] acc_q, acc_d;
  logic [FRAC_W:0]   sum;
  logic [DIV_W-1:0]  half, half_load, int_m1;
  logic              cnt_en;

  always_comb begin
    sum       = {1'b0, acc_q} + {1'b0, div_frac};
    half      = div_int >> 1;
    half_load = (half == '0) ? '0 : half - 1'b1;
    int_m1    = (div_int == '0) ? '0 : div_int - 1'b1;
    tick      = run && (cnt_q == '0);
    cnt_en    = arm | run;
    cnt_d     = cnt_q;
    acc_d     = acc_q;
    if (arm) begin
      cnt_d = half_load;
    end else if (tick) begin
      acc_d = sum[FRAC_W-1:0];
      cnt_d = int_m1 + DIV_W'(sum[FRAC_W]);
    end else if (run) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // only the chip reset clears the fraction accumulator
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    acc_q <= '0;
    else if (tick) acc_q <= acc_d;
  end

  assign acc = acc_q;

endmodule

// File: rtl/frac_rx_fsm.sv
module frac_rx_fsm
  import frac_uart_pkg::*;
#(
  parameter int W  = frac_uart_pkg::WORD_W,
  parameter int NB = frac_uart_pkg::NB_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          line,
  input  logic          fall,
  input  logic          tick,
  input  logic [NB-1:0] nbits_m1,
  output logic          arm,
  output logic          run,
  output logic [W-1:0]  word,
  output logic          valid,
  output logic          ferr
);

  rx_state_e     state_q, state_d;
  logic [NB-1:0] bitcnt_q, bitcnt_d;
  logic [W-1:0]  sr_q, sr_d;
  logic [W-1:0]  word_q;
  logic          valid_q, ferr_q;
  logic          valid_d, sr_en, bc_en;

  always_comb begin
    arm      = en && (state_q == RX_IDLE) && fall;
    run      = en && (state_q != RX_IDLE);
    state_d  = state_q;
    bitcnt_d = bitcnt_q;
    sr_d     = sr_q;
    valid_d  = 1'b0;
    if (!en) begin
      state_d = RX_IDLE;
    end else begin
      unique case (state_q)
        RX_IDLE: begin
          if (fall) begin
            state_d = RX_START;
            sr_d    = '0;
          end
        end
        RX_START: begin
          if (tick) begin
            state_d  = line ? RX_IDLE : RX_DATA;
            bitcnt_d = '0;
          end
        end
        RX_DATA: begin
          if (tick) begin
            sr_d = {line, sr_q[W-1:1]};
            if (bitcnt_q == nbits_m1) state_d = RX_STOP;
            else                      bitcnt_d = bitcnt_q + 1'b1;
          end
        end
        RX_STOP: begin
          if (tick) begin
            valid_d = 1'b1;
            state_d = RX_IDLE;
          end
        end
        default: state_d = RX_IDLE;
      endcase
    end
    sr_en = arm | (tick && (state_q == RX_DATA));
    bc_en = tick && ((state_q == RX_START) || (state_q == RX_DATA));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= RX_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     bitcnt_q <= '0;
    else if (bc_en) bitcnt_q <= bitcnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sr_q <= '0;
    else if (sr_en) sr_q <= sr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       word_q <= '0;
    else if (valid_d) word_q <= sr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      ferr_q  <= 1'b0;
    end else begin
      valid_q <= valid_d;
      ferr_q  <= valid_d & ~line;
    end
  end

  assign word  = word_q;
  assign valid = valid_q;
  assign ferr  = ferr_q;

endmodule

// File: rtl/frac_uart_rx.sv
module frac_uart_rx
  import frac_uart_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rxd,
  input  logic        rx_en,
  input  logic [31:0] baud_cfg,
  output logic [31:0] rx_word,
  output logic        rx_valid,
  output logic        rx_frame_err
);

  logic [1:0]        rst_sync_q;
  logic              rst_i;
  rx_cfg_t           cfg_q;
  logic              cfg_unused;
  logic              line, fall, arm, run, tick;
  logic [FRAC_W-1:0] frac_acc;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  assign cfg_unused = ^baud_cfg[7:5];

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      cfg_q <= '0;
    end else if (!rx_en) begin
      cfg_q.div_int  <= baud_cfg[31:16];
      cfg_q.div_frac <= baud_cfg[15:8];
      cfg_q.nbits_m1 <= baud_cfg[4:0];
    end
  end

  frac_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_i),
    .en    (rx_en),
    .rxd   (rxd),
    .line  (line),
    .fall  (fall)
  );

  frac_bit_timer #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_i),
    .arm      (arm),
    .run      (run),
    .div_int  (cfg_q.div_int),
    .div_frac (cfg_q.div_frac),
    .tick     (tick),
    .acc      (frac_acc)
  );

  frac_rx_fsm #(.W(WORD_W), .NB(NB_W)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_i),
    .en       (rx_en),
    .line     (line),
    .fall     (fall),
    .tick     (tick),
    .nbits_m1 (cfg_q.nbits_m1),
    .arm      (arm),
    .run      (run),
    .word     (rx_word),
    .valid    (rx_valid),
    .ferr     (rx_frame_err)
  );

endmodule

// File: rtl/frac_uart_rx_chk.sv
module frac_uart_rx_chk
  import frac_uart_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              rx_en,
  input logic              rx_valid,
  input logic              rx_frame_err,
  input logic [31:0]       rx_word,
  input rx_cfg_t           cfg_q,
  input logic [FRAC_W-1:0] acc
);

  // R7
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R7
  ferr_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_frame_err |-> rx_valid);

  // R1
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !rx_valid);

  // R10
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> $stable(rx_word));

  // R8
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rx_en) |-> $stable(cfg_q));

  // R6
  acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rx_en) |-> $stable(acc));

endmodule

bind frac_uart_rx frac_uart_rx_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rx_en        (rx_en),
  .rx_valid     (rx_valid),
  .rx_frame_err (rx_frame_err),
  .rx_word      (rx_word),
  .cfg_q        (cfg_q),
  .acc          (frac_acc)
);

// File: tb/frac_uart_rx_tb.sv
module frac_uart_rx_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk;
  logic        rst_n;
  logic        rxd;
  logic        rx_en;
  logic [31:0] baud_cfg;
  logic [31:0] rx_word;
  logic        rx_valid;
  logic        rx_frame_err;

  int tests = 0;
  int fails = 0;
  int cyc   = 0;
  int tx_rem = 0;
  logic [31:0] rxq[$];
  logic        ferrq[$];

  frac_uart_rx u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .rxd          (rxd),
    .rx_en        (rx_en),
    .baud_cfg     (baud_cfg),
    .rx_word      (rx_word),
    .rx_valid     (rx_valid),
    .rx_frame_err (rx_frame_err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] mk_cfg(int ip, int fp, int nb);
    return {ip[15:0], fp[7:0], 3'b000, 5'(nb - 1)};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // ---------------- reference timing model ----------------
  int          m_rs = 0, m_state = 0, m_cnt = 0, m_acc = 0, m_nb = 0;
  logic        m_h1 = 1'b1, m_h2 = 1'b1, m_pv = 1'b0;
  logic [31:0] m_sr = '0, m_word = '0, m_cfg = '0;
  logic        m_valid = 1'b0, m_ferr = 1'b0;

  always @(posedge clk) begin
    int ip, fp, nbm1, half, sum;
    logic line, fall, tick;
    if (!rst_n || m_rs < 2) begin
      if (!rst_n) m_rs = 0; else m_rs++;
      m_state = 0; m_cnt = 0; m_acc = 0; m_nb = 0;
      m_h1 = 1'b1; m_h2 = 1'b1; m_pv = 1'b0;
      m_sr = '0; m_word = '0; m_cfg = '0; m_valid = 0; m_ferr = 0;
    end else begin
      ip   = int'(m_cfg[31:16]);
      fp   = int'(m_cfg[15:8]);
      nbm1 = int'(m_cfg[4:0]);
      half = ip / 2;
      line = m_h2;
      fall = rx_en && m_pv && !line;
      tick = rx_en && m_state != 0 && m_cnt == 0;
      m_valid = 0; m_ferr = 0;
      if (tick) begin
        sum   = m_acc + fp;
        m_acc = sum % 256;
        m_cnt = (ip == 0 ? 0 : ip - 1) + sum / 256;
      end else if (rx_en && m_state != 0) begin
        m_cnt--;
      end
      if (!rx_en) m_state = 0;
      else case (m_state)
        0: if (fall) begin m_state = 1; m_cnt = (half == 0) ? 0 : half - 1; m_sr = '0; end
        1: if (tick) begin m_state = line ? 0 : 2; m_nb = 0; end
        2: if (tick) begin
             m_sr = {line, m_sr[31:1]};
             if (m_nb == nbm1) m_state = 3; else m_nb++;
           end
        default: if (tick) begin
             m_word = m_sr; m_valid = 1; m_ferr = !line; m_state = 0;
           end
      endcase
      if (!rx_en) m_cfg = baud_cfg;
      m_pv = rx_en && line;
      m_h2 = m_h1;
      m_h1 = rxd;
    end
  end

  always @(negedge clk) begin
    if (rx_valid) begin
      rxq.push_back(rx_word);
      ferrq.push_back(rx_frame_err);
    end
    if (rst_n && (rx_valid || m_valid)) begin
      tests++;
      if (rx_valid !== m_valid || rx_word !== m_word || rx_frame_err !== m_ferr) begin
        fails++;
        $display("FAIL R5 cycle model: actual v=%b w=%h e=%b expected v=%b w=%h e=%b",
                 rx_valid, rx_word, rx_frame_err, m_valid, m_word, m_ferr);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected < %0d", cyc, WATCHDOG);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic drive_bit(logic b, int p256);
    int t;
    rxd = b;
    t = tx_rem + p256;
    tx_rem = t % 256;
    repeat (t / 256) @(negedge clk);
  endtask

  task automatic send_frame(logic [31:0] data, int nbits, int nstop, int p256, logic stopv);
    drive_bit(1'b0, p256);
    for (int i = 0; i < nbits; i++) drive_bit(data[i], p256);
    drive_bit(stopv, p256);
    for (int i = 1; i < nstop; i++) drive_bit(1'b1, p256);
    rxd = 1'b1;
  endtask

  task automatic expect_char(string req, logic [31:0] exp, logic ef);
    if (rxq.size() == 0) begin
      tests++; fails++;
      $display("FAIL %s: actual no character expected %h", req, exp);
    end else begin
      check(req, rxq.pop_front(), exp);
      check(req, 32'(ferrq.pop_front()), 32'(ef));
    end
  endtask

  task automatic reconfig(logic [31:0] c);
    rx_en = 1'b0;
    baud_cfg = c;
    repeat (4) @(negedge clk);
    rx_en = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // ---------------- scenarios ----------------
  initial begin
    logic [7:0] b;
    logic [31:0] held;
    rst_n = 1'b0; rxd = 1'b1; rx_en = 1'b0;
    baud_cfg = mk_cfg(10, 0, 8);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    // R1 reset state
    check("R1 reset valid", 32'(rx_valid), 0);
    check("R1 reset ferr", 32'(rx_frame_err), 0);
    check("R1 reset word", rx_word, 0);

    // R9 2 Mbaud 8 data 2 stop, back to back
    rx_en = 1'b1;
    repeat (4) @(negedge clk);
    send_frame(8'h55, 8, 2, 10*256, 1'b1);
    send_frame(8'hA3, 8, 2, 10*256, 1'b1);
    send_frame(8'h00, 8, 2, 10*256, 1'b1);
    send_frame(8'hFF, 8, 2, 10*256, 1'b1);
    repeat (30) @(negedge clk);
    expect_char("R9 char 0x55", 32'h55 << 24, 1'b0);
    expect_char("R9 char 0xA3", 32'hA3 << 24, 1'b0);
    expect_char("R9 char 0x00", 32'h00 << 24, 1'b0);
    expect_char("R9 char 0xFF", 32'hFF << 24, 1'b0);

    // R5 fractional divisor 10.875, one stop bit, long stream
    reconfig(mk_cfg(10, 224, 8));
    for (int i = 0; i < 12; i++) send_frame(8'(i*37 + 5), 8, 1, 2784, 1'b1);
    repeat (30) @(negedge clk);
    for (int i = 0; i < 12; i++) expect_char("R5 fractional stream", 32'(8'(i*37 + 5)) << 24, 1'b0);

    // R6 accumulator kept across disable
    rx_en = 1'b0;
    repeat (10) @(negedge clk);
    rx_en = 1'b1;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 4; i++) send_frame(8'(8'hF0 - i*29), 8, 1, 2784, 1'b1);
    repeat (30) @(negedge clk);
    for (int i = 0; i < 4; i++) expect_char("R6 after re-enable", 32'(8'(8'hF0 - i*29)) << 24, 1'b0);

    // R8 config change while enabled is ignored
    baud_cfg = mk_cfg(30, 0, 8);
    repeat (5) @(negedge clk);
    send_frame(8'h6B, 8, 1, 2784, 1'b1);
    send_frame(8'h92, 8, 1, 2784, 1'b1);
    repeat (30) @(negedge clk);
    expect_char("R8 ignore while enabled a", 32'h6B << 24, 1'b0);
    expect_char("R8 ignore while enabled b", 32'h92 << 24, 1'b0);
    // R8 new word while disabled applies on re-enable
    reconfig(mk_cfg(20, 64, 8));
    send_frame(8'hC4, 8, 2, 20*256 + 64, 1'b1);
    send_frame(8'h1D, 8, 2, 20*256 + 64, 1'b1);
    repeat (50) @(negedge clk);
    expect_char("R8 applied on re-enable a", 32'hC4 << 24, 1'b0);
    expect_char("R8 applied on re-enable b", 32'h1D << 24, 1'b0);

    // R10 word holds between strobes
    held = rx_word;
    repeat (200) @(negedge clk);
    check("R10 word held", rx_word, held);

    // R2 line low at enable does not start a frame
    rx_en = 1'b0;
    rxd = 1'b0;
    repeat (10) @(negedge clk);
    rx_en = 1'b1;
    repeat (300) @(negedge clk);
    check("R2 no frame from low line", 32'(rxq.size()), 0);
    rxd = 1'b1;
    repeat (30) @(negedge clk);
    send_frame(8'h3C, 8, 1, 20*256 + 64, 1'b1);
    repeat (50) @(negedge clk);
    expect_char("R2 frame after high", 32'h3C << 24, 1'b0);

    // R3 short low glitch is rejected at the start re-check
    rxd = 1'b0;
    repeat (3) @(negedge clk);
    rxd = 1'b1;
    repeat (300) @(negedge clk);
    check("R3 glitch dropped", 32'(rxq.size()), 0);
    send_frame(8'hA5, 8, 1, 20*256 + 64, 1'b1);
    repeat (50) @(negedge clk);
    expect_char("R3 frame after glitch", 32'hA5 << 24, 1'b0);

    // R7 stop bit low raises the framing flag
    send_frame(8'h81, 8, 1, 20*256 + 64, 1'b0);
    repeat (60) @(negedge clk);
    expect_char("R7 framing error", 32'h81 << 24, 1'b1);
    send_frame(8'h7E, 8, 1, 20*256 + 64, 1'b1);
    repeat (50) @(negedge clk);
    expect_char("R7 clean stop", 32'h7E << 24, 1'b0);

    // R4 five data bits land at the top
    reconfig(mk_cfg(12, 0, 5));
    send_frame(32'h15, 5, 1, 12*256, 1'b1);
    send_frame(32'h0A, 5, 1, 12*256, 1'b1);
    repeat (40) @(negedge clk);
    expect_char("R4 five bits a", 32'h15 << 27, 1'b0);
    expect_char("R4 five bits b", 32'h0A << 27, 1'b0);

    // R1 disable in the middle of a frame abandons it
    reconfig(mk_cfg(10, 0, 8));
    drive_bit(1'b0, 10*256);
    drive_bit(1'b1, 10*256);
    drive_bit(1'b0, 10*256);
    rx_en = 1'b0;
    for (int i = 0; i < 6; i++) drive_bit(1'b1, 10*256);
    repeat (50) @(negedge clk);
    check("R1 mid-frame disable", 32'(rxq.size()), 0);
    rx_en = 1'b1;
    repeat (5) @(negedge clk);
    b = 8'h5A;
    send_frame(32'(b), 8, 2, 10*256, 1'b1);
    repeat (30) @(negedge clk);
    expect_char("R1 recovery after disable", 32'(b) << 24, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule